// File: doc/BRIEF.md
# Control Endpoint IN Transmit Buffer

This block sits between a processor and a USB serial interface engine. It holds the bytes that a device's control endpoint returns to the host during the data stage of a control read. Software pushes bytes into it one at a time and drives two control bits. The send bit allows the endpoint to answer IN tokens with data. The last-data bit marks the end of the transfer, so the block will send a short or a zero-length packet.

When the serial engine signals an IN token, the block chooses the reply one cycle later: a NAK, a full packet of the maximum packet size, a short packet or a zero-length packet. The engine then pulls the packet's bytes and reports either an acknowledge from the host or a timeout. An acknowledge frees the bytes and drops the send bit. A timeout rewinds the buffer, so the same bytes go out again on the next IN token.

Two protocol events empty the buffer at once. One is a new SETUP token. The other is the early move of the transfer to its status stage, which also drops the send bit.

Top module: `ctl_in_fifo`

## Requirements
- R1: After reset the buffer is empty, and `send_en`, `eod`, `data_present` and `overflow` all read 0.
- R2: `cpu_rd_data` reads 8'h00 at all times, whether the buffer is empty or holds bytes.
- R3: A reply appears on `resp_valid` for exactly one cycle, one clock after an `in_token` strobe. While `send_en` is 0 the reply is NAK: `resp_kind` is 0 and `resp_len` is 0.
- R4: With `send_en` at 1 and at least MPS unacknowledged bytes stored, the reply is a full packet (`resp_kind` 1, `resp_len` equal to MPS). Successive `tx_pull` strobes present the bytes on `tx_data` in the order they were written.
- R5: With `send_en` at 1, fewer than MPS bytes stored and `eod` at 0, the reply is NAK (`resp_kind` 0).
- R6: With `send_en` and `eod` both at 1 and between 1 and MPS-1 bytes stored, the reply is a short packet (`resp_kind` 2) whose `resp_len` is the number of stored bytes.
- R7: With `send_en` and `eod` both at 1 and the buffer empty, the reply is a zero-length packet (`resp_kind` 3, `resp_len` 0). `data_present` reads 1 whenever bytes are stored or `eod` is 1.
- R8: A `tx_ack` for an outstanding packet clears `send_en` and frees the packet's bytes. `eod` is cleared as well if that packet was short or zero-length. A hardware clear wins over a register write in the same cycle.
- R9: A `tx_timeout` for an outstanding packet keeps its bytes, and the next IN token resends the same packet with the same bytes.
- R10: A `setup_evt` strobe empties the buffer, clears `eod` and cancels any outstanding packet. A CPU byte written in the same cycle is discarded.
- R11: A `status_evt` strobe empties the buffer and clears both `send_en` and `eod`.
- R12: While DEPTH unacknowledged bytes are stored, a CPU write is discarded and sets `overflow`. `overflow` then stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr_en | input | 1 | CPU byte write strobe |
| cpu_wr_data | input | 8 | CPU byte to store |
| cpu_rd_data | output | 8 | CPU read view of the data port, always zero |
| reg_wr | input | 1 | Control register write strobe |
| reg_send_en | input | 1 | Value written to the send bit |
| reg_eod | input | 1 | Value written to the last-data bit |
| send_en | output | 1 | Send bit |
| eod | output | 1 | Last-data bit |
| data_present | output | 1 | Bytes stored or last-data bit set |
| overflow | output | 1 | Sticky flag for a write to a full buffer |
| in_token | input | 1 | IN token strobe from the serial engine |
| resp_valid | output | 1 | Reply valid for one cycle |
| resp_kind | output | 2 | 0 NAK, 1 full, 2 short, 3 zero-length |
| resp_len | output | 7 | Byte count of the packet |
| tx_pull | input | 1 | Advance to the next byte of the packet |
| tx_data | output | 8 | Current byte of the outstanding packet |
| tx_ack | input | 1 | Host acknowledged the outstanding packet |
| tx_timeout | input | 1 | Outstanding packet was not acknowledged |
| setup_evt | input | 1 | New SETUP token received |
| status_evt | input | 1 | Transfer entered its status stage |

## Verification
The properties assume a well-behaved serial engine. It raises `in_token` only when no packet is outstanding. It gives at most `resp_len` pulls per packet. It closes each packet with a single acknowledge or timeout, never in the same cycle as a pull. DEPTH is assumed to be a power of two. The stimulus keeps to these assumptions by running every packet as one fixed sequence: token, reply, pulls, then a closing strobe. Each step starts on a falling edge, and no step overlaps another.

// File: rtl/ctl_in_pkg.sv
package ctl_in_pkg;

    // Reply chosen for an IN token; the codes are visible on resp_kind.
    typedef enum logic [1:0] {
        RK_NAK   = 2'd0,
        RK_FULL  = 2'd1,
        RK_SHORT = 2'd2,
        RK_ZLP   = 2'd3
    } resp_kind_e;

endpackage

// File: rtl/ctl_in_store.sv
module ctl_in_store #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/ctl_in_pick.sv
module ctl_in_pick
    import ctl_in_pkg::*;
#(
    parameter int MPS = 8,
    parameter int PW  = 7
) (
    input  logic [PW-1:0] avail,
    input  logic          send_en,
    input  logic          eod,
    output resp_kind_e    kind,
    output logic [PW-1:0] len
);

    always_comb begin
        kind = RK_NAK;
        len  = '0;
        if (send_en) begin
            if (avail >= PW'(MPS)) begin
                kind = RK_FULL;
                len  = PW'(MPS);
            end else if (eod) begin
                if (avail == '0) begin
                    kind = RK_ZLP;
                end else begin
                    kind = RK_SHORT;
                    len  = avail;
                end
            end
        end
    end

endmodule

// File: rtl/ctl_in_fifo.sv
module ctl_in_fifo
    import ctl_in_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int MPS   = 8,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_wr_en,
    input  logic [DW-1:0] cpu_wr_data,
    output logic [DW-1:0] cpu_rd_data,
    input  logic          reg_wr,
    input  logic          reg_send_en,
    input  logic          reg_eod,
    output logic          send_en,
    output logic          eod,
    output logic          data_present,
    output logic          overflow,
    input  logic          in_token,
    output logic          resp_valid,
    output logic [1:0]    resp_kind,
    output logic [PW-1:0] resp_len,
    input  logic          tx_pull,
    output logic [DW-1:0] tx_data,
    input  logic          tx_ack,
    input  logic          tx_timeout,
    input  logic          setup_evt,
    input  logic          status_evt
);

    // Pointers carry one extra bit so that full and empty differ.
    typedef struct packed {
        logic [PW-1:0] wp;      // next write slot
        logic [PW-1:0] rp;      // next byte handed to the engine
        logic [PW-1:0] sp;      // first byte of the unacknowledged packet
        logic          send_en;
        logic          eod;
        logic          ovf;
        logic          busy;    // packet outstanding
        resp_kind_e    kind;
        logic          rvalid;
        logic [PW-1:0] rlen;
    } state_t;

    state_t st_d, st_q;

    logic [PW-1:0] avail;
    logic          full;
    logic          flush;
    logic          wr_ok;
    resp_kind_e    pk_kind;
    logic [PW-1:0] pk_len;
    logic          pkt_busy;

    assign avail    = st_q.wp - st_q.sp;
    assign full     = (avail == PW'(DEPTH));
    assign flush    = setup_evt || status_evt;
    assign wr_ok    = cpu_wr_en && !full && !flush;
    assign pkt_busy = st_q.busy;

    ctl_in_pick #(
        .MPS (MPS),
        .PW  (PW)
    ) u_pick (
        .avail   (avail),
        .send_en (st_q.send_en),
        .eod     (st_q.eod),
        .kind    (pk_kind),
        .len     (pk_len)
    );

    ctl_in_store #(
        .DEPTH (DEPTH),
        .DW    (DW)
    ) u_store (
        .clk   (clk),
        .we    (wr_ok),
        .waddr (st_q.wp[AW-1:0]),
        .wdata (cpu_wr_data),
        .raddr (st_q.rp[AW-1:0]),
        .rdata (tx_data)
    );

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = 1'b0;

        // Software write of the control bits.
        if (reg_wr) begin
            st_d.send_en = reg_send_en;
            st_d.eod     = reg_eod;
        end

        // CPU byte push; a full buffer drops it and flags the loss.
        if (cpu_wr_en) begin
            if (full) begin
                st_d.ovf = 1'b1;
            end else begin
                st_d.wp = st_q.wp + 1'b1;
            end
        end

        // Engine pulls the next byte of the outstanding packet.
        if (tx_pull && st_q.busy) begin
            st_d.rp = st_q.rp + 1'b1;
        end

        // Reply selection for an IN token.
        if (in_token && !st_q.busy) begin
            st_d.rvalid = 1'b1;
            st_d.kind   = pk_kind;
            st_d.rlen   = pk_len;
            st_d.busy   = (pk_kind != RK_NAK);
        end

        // Host accepted the packet: release it and drop the send bit.
        if (tx_ack && st_q.busy) begin
            st_d.sp      = st_q.rp;
            st_d.busy    = 1'b0;
            st_d.send_en = 1'b0;
            if (st_q.kind == RK_SHORT || st_q.kind == RK_ZLP) begin
                st_d.eod = 1'b0;
            end
        end

        // No handshake: rewind so the same bytes go out again.
        if (tx_timeout && st_q.busy) begin
            st_d.rp   = st_q.sp;
            st_d.busy = 1'b0;
        end

        // Protocol flushes override everything above.
        if (flush) begin
            st_d.wp     = '0;
            st_d.rp     = '0;
            st_d.sp     = '0;
            st_d.busy   = 1'b0;
            st_d.eod    = 1'b0;
            st_d.rvalid = 1'b0;
            if (status_evt) begin
                st_d.send_en = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{wp: '0, rp: '0, sp: '0, send_en: 1'b0, eod: 1'b0,
                      ovf: 1'b0, busy: 1'b0, kind: RK_NAK, rvalid: 1'b0,
                      rlen: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cpu_rd_data  = '0;
    assign send_en      = st_q.send_en;
    assign eod          = st_q.eod;
    assign overflow     = st_q.ovf;
    assign data_present = (st_q.wp != st_q.sp) || st_q.eod;
    assign resp_valid   = st_q.rvalid;
    assign resp_kind    = st_q.kind;
    assign resp_len     = st_q.rlen;

endmodule

// File: rtl/ctl_in_fifo_chk.sv
module ctl_in_fifo_chk
    import ctl_in_pkg::*;
#(
    parameter int MPS = 8,
    parameter int PW  = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_token,
    input logic          send_en,
    input logic          eod,
    input logic          data_present,
    input logic          overflow,
    input logic          resp_valid,
    input logic [1:0]    resp_kind,
    input logic [PW-1:0] resp_len,
    input logic          tx_ack,
    input logic          pkt_busy,
    input logic          setup_evt,
    input logic          status_evt
);

    assert_resp_after_token_R3: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $past(in_token));

    assert_nak_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_token && !send_en && !pkt_busy && !setup_evt && !status_evt)
        |=> (resp_valid && resp_kind == 2'(RK_NAK) && resp_len == '0));

    assert_full_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_kind == 2'(RK_FULL)) |-> resp_len == PW'(MPS));

    assert_short_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_kind == 2'(RK_SHORT)) |-> (resp_len != '0 && resp_len < PW'(MPS)));

    assert_zlp_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_kind == 2'(RK_ZLP)) |-> resp_len == '0);

    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ack && pkt_busy) |=> !send_en);

    assert_setup_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        setup_evt |=> (!data_present && !eod && !pkt_busy));

    assert_status_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        status_evt |=> (!send_en && !data_present));

    assert_ovf_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

endmodule

bind ctl_in_fifo ctl_in_fifo_chk #(
    .MPS (MPS),
    .PW  (PW)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_token     (in_token),
    .send_en      (send_en),
    .eod          (eod),
    .data_present (data_present),
    .overflow     (overflow),
    .resp_valid   (resp_valid),
    .resp_kind    (resp_kind),
    .resp_len     (resp_len),
    .tx_ack       (tx_ack),
    .pkt_busy     (pkt_busy),
    .setup_evt    (setup_evt),
    .status_evt   (status_evt)
);

// File: tb/tb_ctl_in_fifo.sv
module tb_ctl_in_fifo;

    localparam int DEPTH = 64;
    localparam int MPS   = 8;
    localparam int PW    = 7;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          cpu_wr_en = 1'b0;
    logic [7:0]    cpu_wr_data = '0;
    logic [7:0]    cpu_rd_data;
    logic          reg_wr = 1'b0, reg_send_en = 1'b0, reg_eod = 1'b0;
    logic          send_en, eod, data_present, overflow;
    logic          in_token = 1'b0;
    logic          resp_valid;
    logic [1:0]    resp_kind;
    logic [PW-1:0] resp_len;
    logic          tx_pull = 1'b0;
    logic [7:0]    tx_data;
    logic          tx_ack = 1'b0, tx_timeout = 1'b0;
    logic          setup_evt = 1'b0, status_evt = 1'b0;

    ctl_in_fifo #(.DEPTH(DEPTH), .MPS(MPS)) dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data), .cpu_rd_data(cpu_rd_data),
        .reg_wr(reg_wr), .reg_send_en(reg_send_en), .reg_eod(reg_eod),
        .send_en(send_en), .eod(eod), .data_present(data_present), .overflow(overflow),
        .in_token(in_token), .resp_valid(resp_valid), .resp_kind(resp_kind),
        .resp_len(resp_len), .tx_pull(tx_pull), .tx_data(tx_data),
        .tx_ack(tx_ack), .tx_timeout(tx_timeout),
        .setup_evt(setup_evt), .status_evt(status_evt)
    );

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        logic [1:0] kind;
        int         len;
        string      tag;
    } exp_t;

    exp_t        exp_q[$];
    logic [7:0]  model_q[$];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Monitor: every reply is popped from the scoreboard and compared.
    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            if (exp_q.size() == 0) begin
                n_chk++;
                n_bad++;
                $display("FAIL R3: unexpected reply actual kind %0d expected none", resp_kind);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk({e.tag, " kind"}, 32'(resp_kind), 32'(e.kind));
                chk({e.tag, " len"}, 32'(resp_len), 32'(e.len));
            end
        end
    end

    task automatic wr_byte(input logic [7:0] b, input bit accept);
        cpu_wr_en = 1'b1;
        cpu_wr_data = b;
        @(negedge clk);
        cpu_wr_en = 1'b0;
        if (accept) model_q.push_back(b);
    endtask

    task automatic reg_set(input logic se, input logic eo);
        reg_wr = 1'b1;
        reg_send_en = se;
        reg_eod = eo;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic in_req(input logic [1:0] kind, input int len, input string tag);
        exp_t e;
        e.kind = kind;
        e.len  = len;
        e.tag  = tag;
        exp_q.push_back(e);
        in_token = 1'b1;
        @(negedge clk);
        in_token = 1'b0;
        @(negedge clk);
    endtask

    task automatic pull_pkt(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            chk({tag, " byte"}, 32'(tx_data), 32'(model_q[i]));
            tx_pull = 1'b1;
            @(negedge clk);
            tx_pull = 1'b0;
        end
    endtask

    task automatic ack_pkt(input int n);
        tx_ack = 1'b1;
        @(negedge clk);
        tx_ack = 1'b0;
        for (int i = 0; i < n; i++) void'(model_q.pop_front());
    endtask

    task automatic timeout_pkt();
        tx_timeout = 1'b1;
        @(negedge clk);
        tx_timeout = 1'b0;
    endtask

    task automatic finish_run();
        chk("R3 all replies seen", 32'(exp_q.size()), 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state, R2 read view
        chk("R1 send_en", 32'(send_en), 0);
        chk("R1 eod", 32'(eod), 0);
        chk("R1 data_present", 32'(data_present), 0);
        chk("R1 overflow", 32'(overflow), 0);
        chk("R2 read empty", 32'(cpu_rd_data), 0);

        // R3 NAK while send bit is off
        in_req(2'd0, 0, "R3 empty");
        for (int i = 0; i < 3; i++) wr_byte(8'h10 + 8'(i), 1'b1);
        chk("R7 present with bytes", 32'(data_present), 1);
        chk("R2 read with data", 32'(cpu_rd_data), 0);
        in_req(2'd0, 0, "R3 bytes held");

        // R5 too few bytes and no end mark
        reg_set(1'b1, 1'b0);
        in_req(2'd0, 0, "R5 partial");

        // R4 full packet, R9 timeout resend, R8 ack
        for (int i = 3; i < 8; i++) wr_byte(8'h10 + 8'(i), 1'b1);
        in_req(2'd1, MPS, "R4 full");
        pull_pkt(MPS, "R4");
        timeout_pkt();
        in_req(2'd1, MPS, "R9 resend");
        pull_pkt(MPS, "R9");
        ack_pkt(MPS);
        chk("R8 send cleared", 32'(send_en), 0);
        chk("R8 buffer freed", 32'(data_present), 0);

        // R6 short packet
        for (int i = 0; i < 3; i++) wr_byte(8'hA0 + 8'(i), 1'b1);
        reg_set(1'b1, 1'b1);
        in_req(2'd2, 3, "R6 short");
        pull_pkt(3, "R6");
        ack_pkt(3);
        chk("R8 eod cleared after short", 32'(eod), 0);
        chk("R8 send cleared after short", 32'(send_en), 0);

        // R7 zero-length packet
        reg_set(1'b1, 1'b1);
        chk("R7 present with only end mark", 32'(data_present), 1);
        in_req(2'd3, 0, "R7 zlp");
        ack_pkt(0);
        chk("R8 eod cleared after zlp", 32'(eod), 0);

        // R10 setup flush
        for (int i = 0; i < 5; i++) wr_byte(8'h50 + 8'(i), 1'b1);
        setup_evt = 1'b1;
        @(negedge clk);
        setup_evt = 1'b0;
        model_q.delete();
        chk("R10 emptied", 32'(data_present), 0);
        for (int i = 0; i < 3; i++) wr_byte(8'hC0 + 8'(i), 1'b1);
        reg_set(1'b1, 1'b1);
        in_req(2'd2, 3, "R10 only new bytes");
        pull_pkt(3, "R10");
        ack_pkt(3);

        // R11 status stage flush
        for (int i = 0; i < 4; i++) wr_byte(8'h70 + 8'(i), 1'b1);
        reg_set(1'b1, 1'b0);
        status_evt = 1'b1;
        @(negedge clk);
        status_evt = 1'b0;
        model_q.delete();
        chk("R11 send cleared", 32'(send_en), 0);
        chk("R11 emptied", 32'(data_present), 0);
        reg_set(1'b1, 1'b1);
        in_req(2'd3, 0, "R11 zlp after flush");
        ack_pkt(0);

        // R12 full buffer drops writes
        for (int i = 0; i < DEPTH; i++) wr_byte(8'(i) ^ 8'h5A, 1'b1);
        chk("R12 no overflow at full", 32'(overflow), 0);
        wr_byte(8'hEE, 1'b0);
        chk("R12 overflow set", 32'(overflow), 1);
        for (int p = 0; p < DEPTH / MPS; p++) begin
            reg_set(1'b1, 1'b0);
            in_req(2'd1, MPS, "R12 drain");
            pull_pkt(MPS, "R12");
            ack_pkt(MPS);
        end
        reg_set(1'b1, 1'b1);
        in_req(2'd3, 0, "R12 dropped byte absent");
        ack_pkt(0);
        chk("R12 overflow sticky", 32'(overflow), 1);
        chk("R2 read after traffic", 32'(cpu_rd_data), 0);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule